// File: doc/BRIEF.md
# Set/Clear GPIO Pin Bank

This block is a bank of general-purpose pins behind a single-cycle register port (address, write enable, write data, read data). Software never writes an output level or a direction bit directly. Each pin's output level and its driver enable are changed through paired registers: one where every 1 in the written word sets the matching bit, and one where every 1 clears it. A single pin can therefore be raised, lowered, driven or released without a read-modify-write, and two agents working on different pins cannot overwrite each other's changes.

Input levels reach software through a separate read-only register. Each pin is sampled by a chain of synchronizer flops first, so the value read is the pin level from a fixed number of clock edges earlier. The pad side is split into a drive value and a drive enable per pin, for a tri-state pad cell outside the block. A pin whose enable bit is 0 is left undriven.

The window is 0x100 bytes of 32-bit little-endian words. Bit n of every register and of every written word belongs to pin n.

Top module: `pin_bank_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the output-level register and the enable register, so every pad_oe and pad_out bit is 0 and reads of 0x00, 0x10, 0x20 and 0x30 return 0.
- R2: A write to offset 0x00 sets the output-level bit of every pin whose bit in bus_wdata is 1. Pins with a 0 keep their level. The new value is visible from the clock edge that takes the write.
- R3: A write to offset 0x10 clears the output-level bit of every pin whose bit in bus_wdata is 1. Pins with a 0 keep their level, and a write of all zeros changes nothing.
- R4: A write to offset 0x20 sets the enable bit of every pin marked 1. A write to offset 0x30 clears the enable bit of every pin marked 1. Unmarked pins keep their enable.
- R5: Reading offset 0x00 or 0x10 returns the output-level register. Reading 0x20 or 0x30 returns the enable register. Read data is combinational from bus_addr, with pin n at bit n.
- R6: Reading offset 0x40 returns pad_in after SYNC_STAGES clock edges (2 by default), pin n at bit n. A change on pad_in is not visible after one edge. Writes to 0x40 change no register.
- R7: Any other address, including non-word-aligned ones such as 0x04, reads as 0, and a write to it changes neither register.
- R8: pad_oe[n] equals enable bit n. pad_out[n] equals output-level bit n when that enable bit is 1, and 0 otherwise.
- R9: With bus_we low, no register changes, whatever the address and data.
- R10: Bits of bus_wdata at positions NUM_PINS and above are ignored, and read-data bits at those positions are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_we | input | 1 | Write enable, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data, bit n for pin n |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Raw pin levels from the pads, asynchronous |
| pad_out | output | NUM_PINS | Drive value per pad, 0 while undriven |
| pad_oe | output | NUM_PINS | Drive enable per pad, 0 leaves the pad high-impedance |

## Verification
The bench builds the bank with NUM_PINS set to 24, below the 32-bit bus width, and keeps SYNC_STAGES at 2 and ADDR_W at 8. With this narrower bank, writes that carry ones in bits 24 to 31 and reads that must show zeros there can both be exercised, which is not possible at the default width. With the two-stage synchronizer, the bench checks the exact edge at which a pad change reaches the input register: not after the first edge, and present after the second.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  localparam int unsigned BUS_W = 32;

  // Word offsets within the window; software decodes on these values.
  localparam int unsigned OFS_OUT_SET = 'h00;
  localparam int unsigned OFS_OUT_CLR = 'h10;
  localparam int unsigned OFS_EN_SET  = 'h20;
  localparam int unsigned OFS_EN_CLR  = 'h30;
  localparam int unsigned OFS_IN      = 'h40;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_IN   = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic out_set;
    logic out_clr;
    logic en_set;
    logic en_clr;
  } wr_strobe_t;

  // Next value of one register bit under a set/clear write pair.
  function automatic logic next_bit(input logic cur, input logic set_hit,
                                    input logic clr_hit);
    if (set_hit)      return 1'b1;
    else if (clr_hit) return 1'b0;
    else              return cur;
  endfunction

  // Place a pin-wide vector in the low bits of a bus word.
  function automatic logic [BUS_W-1:0] widen(input logic [BUS_W-1:0] pins,
                                             input int unsigned npins);
    logic [BUS_W-1:0] w;
    for (int unsigned b = 0; b < BUS_W; b++) begin
      w[b] = (b < npins) ? pins[b] : 1'b0;
    end
    return w;
  endfunction

endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
  import pin_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_strobe_t        strb,
  output rd_sel_e           sel
);

  localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(OFS_OUT_SET);
  localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(OFS_OUT_CLR);
  localparam logic [ADDR_W-1:0] A_EN_SET  = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR  = ADDR_W'(OFS_EN_CLR);
  localparam logic [ADDR_W-1:0] A_IN      = ADDR_W'(OFS_IN);

  logic hit_out_set, hit_out_clr, hit_en_set, hit_en_clr, hit_in;

  always_comb begin
    hit_out_set = (addr == A_OUT_SET);
    hit_out_clr = (addr == A_OUT_CLR);
    hit_en_set  = (addr == A_EN_SET);
    hit_en_clr  = (addr == A_EN_CLR);
    hit_in      = (addr == A_IN);
  end

  always_comb begin
    strb.out_set = we & hit_out_set;
    strb.out_clr = we & hit_out_clr;
    strb.en_set  = we & hit_en_set;
    strb.en_clr  = we & hit_en_clr;
  end

  always_comb begin
    if (hit_out_set || hit_out_clr)    sel = SEL_OUT;
    else if (hit_en_set || hit_en_clr) sel = SEL_EN;
    else if (hit_in)                   sel = SEL_IN;
    else                               sel = SEL_NONE;
  end

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.out_set, strb.out_clr, strb.en_set, strb.en_clr}));

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> (strb == '0));

  // R7
  unmapped_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (strb == '0));

endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wr_strobe_t          strb,
  input  logic [NUM_PINS-1:0] wmask,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] en_q
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic lvl_b, en_b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_b <= 1'b0;
        en_b  <= 1'b0;
      end else begin
        lvl_b <= next_bit(lvl_b, strb.out_set & wmask[i], strb.out_clr & wmask[i]);
        en_b  <= next_bit(en_b,  strb.en_set  & wmask[i], strb.en_clr  & wmask[i]);
      end
    end

    assign out_q[i] = lvl_b;
    assign en_q[i]  = en_b;
  end

  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.out_set |=> ((out_q & $past(wmask)) == $past(wmask)) &&
                     ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.out_clr |=> ((out_q & $past(wmask)) == '0) &&
                     ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.en_set |=> ((en_q & $past(wmask)) == $past(wmask)) && $stable(out_q));

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.en_clr |=> ((en_q & $past(wmask)) == '0) && $stable(out_q));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == '0) |=> $stable(out_q) && $stable(en_q));

endmodule

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] raw_in,
  output logic [NUM_PINS-1:0] sync_out
);

  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    logic [NUM_PINS-1:0] src;
    if (s == 0) begin : g_first
      assign src = raw_in;
    end else begin : g_next
      assign src = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= src;
    end
  end

  assign sync_out = stage_q[SYNC_STAGES-1];

  if (SYNC_STAGES == 2) begin : g_two_stage_chk
    logic [1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst_q <= 2'd0;
      else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
    end

    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q == 2'd2) |-> (sync_out == $past(raw_in, 2)));
  end

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  localparam int unsigned PAD_W = NUM_PINS;

  wr_strobe_t           strb;
  rd_sel_e              sel;
  logic [PAD_W-1:0]     out_q, en_q, in_sync;
  logic [PAD_W-1:0]     wmask;
  logic [BUS_W-1:0]     out_word, en_word, in_word;

  assign wmask = bus_wdata[PAD_W-1:0];

  pin_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (bus_addr),
    .we   (bus_we),
    .strb (strb),
    .sel  (sel)
  );

  pin_bank_regs #(.NUM_PINS(PAD_W)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .strb (strb),
    .wmask(wmask),
    .out_q(out_q),
    .en_q (en_q)
  );

  pin_bank_sync #(.NUM_PINS(PAD_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_in  (pad_in),
    .sync_out(in_sync)
  );

  always_comb begin
    out_word = widen(BUS_W'(out_q), PAD_W);
    en_word  = widen(BUS_W'(en_q), PAD_W);
    in_word  = widen(BUS_W'(in_sync), PAD_W);
  end

  always_comb begin
    unique case (sel)
      SEL_OUT: bus_rdata = out_word;
      SEL_EN:  bus_rdata = en_word;
      SEL_IN:  bus_rdata = in_word;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar p = 0; p < PAD_W; p++) begin : g_pad
    assign pad_oe[p]  = en_q[p];
    assign pad_out[p] = en_q[p] & out_q[p];
  end

  // R8
  pad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0) && ((pad_out & ~out_q) == '0));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pad_oe == '0) && (pad_out == '0));

endmodule

// File: tb/pin_bank_ctrl_test.sv
module pin_bank_ctrl_test;

  localparam int unsigned NP = 24;
  localparam logic [31:0] PIN_MASK = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 8'h00, 32'h0000_00F0, 8'h00, 32'h0000_00F0}, // R2 set
    '{4'd2,  1'b1, 8'h00, 32'h0000_0003, 8'h00, 32'h0000_00F3}, // R2 others kept
    '{4'd3,  1'b1, 8'h10, 32'h0000_0030, 8'h10, 32'h0000_00C3}, // R3 clear
    '{4'd3,  1'b1, 8'h10, 32'h0000_0000, 8'h00, 32'h0000_00C3}, // R3 zero word
    '{4'd4,  1'b1, 8'h20, 32'h0000_0F0F, 8'h20, 32'h0000_0F0F}, // R4 enable set
    '{4'd4,  1'b1, 8'h30, 32'h0000_0003, 8'h30, 32'h0000_0F0C}, // R4 enable clear
    '{4'd10, 1'b1, 8'h00, 32'hFFFF_FFFF, 8'h00, 32'h00FF_FFFF}, // R10 high bits zero
    '{4'd10, 1'b1, 8'h10, 32'hFF00_0000, 8'h00, 32'h00FF_FFFF}, // R10 high bits ignored
    '{4'd7,  1'b1, 8'h50, 32'h0000_1234, 8'h50, 32'h0000_0000}, // R7 unmapped read
    '{4'd9,  1'b0, 8'h10, 32'hFFFF_FFFF, 8'h00, 32'h00FF_FFFF}, // R9 no write
    '{4'd7,  1'b1, 8'h24, 32'hFFFF_FFFF, 8'h20, 32'h0000_0F0C}, // R7 unaligned ignored
    '{4'd5,  1'b1, 8'h10, 32'h00FF_0000, 8'h10, 32'h0000_FFFF}, // R5 readback
    '{4'd6,  1'b1, 8'h40, 32'h00FF_FFFF, 8'h00, 32'h0000_FFFF}  // R6 input write ignored
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 pad_out", 32'(pad_out), 32'h0);
    bus_read(8'h00, rd); check("R1 out reg", rd, 32'h0);
    bus_read(8'h30, rd); check("R1 en reg", rd, 32'h0);

    for (int v = 0; v < NV; v++) begin
      bus_write(VECS[v].we, VECS[v].waddr, VECS[v].wdata);
      bus_read(VECS[v].raddr, rd);
      checks++;
      if (rd !== VECS[v].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d: got %h expected %h", VECS[v].req, v, rd, VECS[v].exp);
      end
    end

    // R8 pads: enable 0x0F0C, level 0xFFFF
    check("R8 pad_oe", 32'(pad_oe), 32'h0000_0F0C);
    check("R8 pad_out", 32'(pad_out), 32'h0000_0F0C);

    // R5 both enable offsets read the same register
    bus_read(8'h20, rd); check("R5 en via 0x20", rd, 32'h0000_0F0C);

    // R6 input synchronizer: two edges of latency
    @(negedge clk);
    pad_in = 24'hA5A5A5;
    bus_addr = 8'h40;
    @(posedge clk);
    @(negedge clk);
    bus_read(8'h40, rd); check("R6 after one edge", rd, 32'h0);
    @(posedge clk);
    @(negedge clk);
    bus_read(8'h40, rd); check("R6 after two edges", rd, 32'h00A5_A5A5 & PIN_MASK);

    // R1 mid-run reset clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid reset pad_oe", 32'(pad_oe), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(8'h10, rd); check("R1 mid reset out reg", rd, 32'h0);

    finish_run();
  end

endmodule